// File: doc/BRIEF.md
# Event Pulse Transfer Across Unrelated Clocks

This block carries single-cycle event pulses from one clock domain into another whose clock has no fixed relation to the first. Events may arrive on every source cycle. No event is lost while the number still waiting stays below the counter range. The source side counts accepted events in a binary counter and keeps a registered Gray-coded copy of it. Only that copy crosses into the destination domain, through a chain of flops. A Gray count changes one bit per step, so a sample taken in the middle of a change reads either the old or the new value, never anything else.

The destination side holds its own count of the events it has already reproduced. While that count differs from the synchronized source count, it emits one pulse per clock and steps its count once per pulse. A backlog therefore drains as a run of consecutive high cycles, and each high cycle stands for one event. The destination count is also synchronized back into the source domain. There the source side works out how many events are still waiting. If the waiting count has reached the largest value the counter can hold, a new event is refused and a sticky overflow flag is set.

The destination logic is a two-state machine. In `ST_IDLE` the output is low. In `ST_DRAIN` the output is high for that cycle. Both states move to `ST_DRAIN` when the counts differ ("pending") and to `ST_IDLE` when they match ("caught up").

Top module: `evt_xfer_gray`

## Requirements
- R1: While either reset is low, and after both are released, `dst_evt` and `src_ovf` are 0 and both counts are zero. After reset, no pulse appears at `dst_evt` until a new pulse arrives at `src_evt`.
- R2: Each accepted source pulse raises the source count by exactly one. The registered Gray copy changes by at most one bit per source cycle.
- R3: The Gray copy is taken from a register and crosses through `SYNC_STAGES` flops (default 2). An isolated pulse appears at `dst_evt` no later than `SYNC_STAGES`+3 destination falling edges after the source edge that accepts it.
- R4: Over any stretch that starts and ends idle, the number of destination cycles with `dst_evt` high equals the number of accepted source pulses. This holds for pulse spacings of 1 to 4 source cycles.
- R5: `dst_evt` stands for at most one event per destination cycle. A backlog of k pending events drains as exactly k consecutive high cycles.
- R6: Bursts of 1 to 15 back-to-back source pulses (default `CNT_W`=4) are all reproduced.
- R7: The destination count changes only in a cycle where `dst_evt` is high, and then it changes by exactly one Gray step.
- R8: A source pulse that arrives while the source side sees 2^`CNT_W`-1 events waiting is refused and sets `src_ovf`. With 15 events waiting (default width) the 16th is refused and the first 15 are still reproduced. `src_ovf` stays 1 until `src_rst_n` goes low.
- R9: `src_ovf` rises only in the source cycle that follows a pulse on `src_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, asynchronous, active low |
| src_evt | input | 1 | Event pulse; each high source cycle is one event |
| src_ovf | output | 1 | Sticky flag: an event was refused because too many were waiting |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, asynchronous, active low |
| dst_evt | output | 1 | Regenerated event pulse; each high destination cycle is one event |

## Verification
The source side records an accepted pulse at the source edge that samples it, and `src_ovf` is due one source cycle after a refused pulse. The bench samples the flag two source cycles later. At the destination, a pulse needs the synchronizer stages plus the state register, so it is due within `SYNC_STAGES`+3 destination falling edges. The bench counts those edges for every isolated pulse. After each burst, the bench waits long enough for the whole backlog to drain before it compares the pulse counts. To build a known backlog, the bench stops the destination clock, sends the events, and restarts the clock. It then measures the longest run of high `dst_evt` cycles.

// File: rtl/gxs_pkg.sv
`timescale 1ns/100ps
package gxs_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } regen_state_t;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        for (int i = 0; i < 32; i++) begin
            b[i] = ^(g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/gxs_sync.sv
`timescale 1ns/100ps
module gxs_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gxs_src_counter.sv
`timescale 1ns/100ps
module gxs_src_counter #(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic             src_evt,
    input  logic [CNT_W-1:0] dst_gray_async,
    output logic [CNT_W-1:0] src_gray,
    output logic             src_ovf
);
    import gxs_pkg::*;

    localparam logic [CNT_W-1:0] MAX_WAIT = '1;

    logic [CNT_W-1:0] dst_gray_s;
    logic [CNT_W-1:0] dst_bin_s;
    logic [CNT_W-1:0] src_bin;
    logic [CNT_W-1:0] src_bin_nxt;
    logic [CNT_W-1:0] waiting;
    logic             at_limit;
    logic             accept;

    gxs_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_back_sync (
        .clk     (src_clk),
        .rst_n   (src_rst_n),
        .d_async (dst_gray_async),
        .q_sync  (dst_gray_s)
    );

    always_comb begin
        dst_bin_s   = CNT_W'(from_gray(32'(dst_gray_s)));
        waiting     = src_bin - dst_bin_s;
        at_limit    = (waiting == MAX_WAIT);
        accept      = src_evt && !at_limit;
        src_bin_nxt = accept ? src_bin + 1'b1 : src_bin;
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            src_bin  <= '0;
            src_gray <= '0;
            src_ovf  <= 1'b0;
        end else begin
            src_bin  <= src_bin_nxt;
            src_gray <= CNT_W'(to_gray(32'(src_bin_nxt)));
            if (src_evt && at_limit) src_ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/gxs_dst_regen.sv
`timescale 1ns/100ps
module gxs_dst_regen #(
    parameter int CNT_W = 4
) (
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    input  logic [CNT_W-1:0] src_gray_s,
    output logic [CNT_W-1:0] dst_gray,
    output logic             dst_evt
);
    import gxs_pkg::*;

    regen_state_t     state_q;
    regen_state_t     state_nxt;
    logic [CNT_W-1:0] dst_bin;
    logic [CNT_W-1:0] dst_bin_nxt;
    logic             pending;

    assign pending = (src_gray_s != dst_gray);

    always_comb begin
        state_nxt   = state_q;
        dst_bin_nxt = dst_bin;
        unique case (state_q)
            ST_IDLE: begin
                if (pending) begin
                    state_nxt   = ST_DRAIN;
                    dst_bin_nxt = dst_bin + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (pending) begin
                    dst_bin_nxt = dst_bin + 1'b1;
                end else begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            state_q  <= ST_IDLE;
            dst_bin  <= '0;
            dst_gray <= '0;
        end else begin
            state_q  <= state_nxt;
            dst_bin  <= dst_bin_nxt;
            dst_gray <= CNT_W'(to_gray(32'(dst_bin_nxt)));
        end
    end

    always_comb begin
        dst_evt = (state_q == ST_DRAIN);
    end

endmodule

// File: rtl/evt_xfer_gray.sv
`timescale 1ns/100ps
module evt_xfer_gray #(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_evt,
    output logic src_ovf,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_evt
);

    logic [CNT_W-1:0] src_gray_q;
    logic [CNT_W-1:0] src_gray_s;
    logic [CNT_W-1:0] dst_gray_q;

    gxs_src_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
        .src_clk        (src_clk),
        .src_rst_n      (src_rst_n),
        .src_evt        (src_evt),
        .dst_gray_async (dst_gray_q),
        .src_gray       (src_gray_q),
        .src_ovf        (src_ovf)
    );

    gxs_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_fwd_sync (
        .clk     (dst_clk),
        .rst_n   (dst_rst_n),
        .d_async (src_gray_q),
        .q_sync  (src_gray_s)
    );

    gxs_dst_regen #(.CNT_W(CNT_W)) u_dst (
        .dst_clk    (dst_clk),
        .dst_rst_n  (dst_rst_n),
        .src_gray_s (src_gray_s),
        .dst_gray   (dst_gray_q),
        .dst_evt    (dst_evt)
    );

endmodule

// File: rtl/gxs_checker.sv
`timescale 1ns/100ps
module gxs_checker #(
    parameter int CNT_W = 4
) (
    input logic             src_clk,
    input logic             src_rst_n,
    input logic             src_evt,
    input logic             src_ovf,
    input logic [CNT_W-1:0] src_gray,
    input logic             dst_clk,
    input logic             dst_rst_n,
    input logic             dst_evt,
    input logic [CNT_W-1:0] dst_gray
);

    AST_SRC_GRAY_STEP: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $countones(src_gray ^ $past(src_gray)) <= 1); // R2

    AST_OVF_STICKY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_ovf |=> src_ovf); // R8

    AST_OVF_CAUSE: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $rose(src_ovf) |-> $past(src_evt)); // R9

    AST_DST_ONE_STEP: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_evt |-> ($countones(dst_gray ^ $past(dst_gray)) == 1)); // R7

    AST_DST_HOLD: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !dst_evt |-> $stable(dst_gray)); // R7

endmodule

bind evt_xfer_gray gxs_checker #(.CNT_W(CNT_W)) u_chk (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_evt   (src_evt),
    .src_ovf   (src_ovf),
    .src_gray  (src_gray_q),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_evt   (dst_evt),
    .dst_gray  (dst_gray_q)
);

// File: tb/evt_xfer_gray_tb.sv
`timescale 1ns/100ps
module evt_xfer_gray_tb;

    localparam int SYNC_STAGES = 2;
    localparam int LAT_LIMIT   = SYNC_STAGES + 3;

    logic src_clk = 1'b0;
    logic dst_clk = 1'b0;
    logic src_rst_n = 1'b0;
    logic dst_rst_n = 1'b0;
    logic src_evt = 1'b0;
    logic src_ovf;
    logic dst_evt;
    logic dst_run = 1'b1;
    logic done = 1'b0;

    int checks = 0;
    int errors = 0;
    int in_cnt = 0;
    int out_cnt = 0;
    int run_len = 0;
    int max_run = 0;
    int lat_cnt = 0;
    logic lat_arm = 1'b0;

    evt_xfer_gray #(.CNT_W(4), .SYNC_STAGES(SYNC_STAGES)) u_dut (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .src_evt   (src_evt),
        .src_ovf   (src_ovf),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .dst_evt   (dst_evt)
    );

    always #4 src_clk = ~src_clk;

    initial begin
        #1.3;
        forever begin
            #6.5;
            if (dst_run) dst_clk = ~dst_clk;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge dst_clk) begin
        if (dst_rst_n) begin
            if (lat_arm) lat_cnt++;
            if (dst_evt) begin
                out_cnt++;
                run_len++;
                if (run_len > max_run) max_run = run_len;
                if (lat_arm) begin
                    lat_arm = 1'b0;
                    chk(lat_cnt <= LAT_LIMIT, "R3 latency", lat_cnt, LAT_LIMIT);
                end
            end else begin
                run_len = 0;
            end
        end
    end

    task automatic src_wait(input int n);
        repeat (n) @(negedge src_clk);
    endtask

    task automatic burst(input int len, input int gap);
        for (int i = 0; i < len; i++) begin
            @(negedge src_clk);
            src_evt = 1'b1;
            @(negedge src_clk);
            src_evt = 1'b0;
            if (gap > 1) src_wait(gap - 1);
        end
    endtask

    task automatic back_to_back(input int len);
        @(negedge src_clk);
        src_evt = 1'b1;
        src_wait(len);
        src_evt = 1'b0;
    endtask

    initial begin
        src_wait(6);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        chk(dst_evt == 1'b0, "R1 dst_evt after reset", dst_evt, 0);
        chk(src_ovf == 1'b0, "R1 ovf after reset", src_ovf, 0);
        src_wait(40);
        chk(out_cnt == 0, "R1 no spurious pulse", out_cnt, 0);

        // R3: isolated pulses, latency measured by the monitor
        for (int k = 0; k < 6; k++) begin
            @(negedge src_clk);
            src_evt = 1'b1;
            @(posedge src_clk);
            lat_cnt = 0;
            lat_arm = 1'b1;
            @(negedge src_clk);
            src_evt = 1'b0;
            in_cnt++;
            src_wait(20 + 3 * k);
            chk(lat_arm == 1'b0, "R3 pulse seen", lat_arm, 0);
        end
        chk(out_cnt == in_cnt, "R4 sparse count", out_cnt, in_cnt);

        // R6 / R2: back-to-back bursts of every length 1..15
        for (int len = 1; len <= 15; len++) begin
            back_to_back(len);
            in_cnt += len;
            src_wait(45);
            chk(out_cnt == in_cnt, "R6 burst count (R2)", out_cnt, in_cnt);
        end

        // R4: spacings 1..4
        for (int gap = 1; gap <= 4; gap++) begin
            burst(8, gap);
            in_cnt += 8;
            src_wait(45);
            chk(out_cnt == in_cnt, "R4 spaced count", out_cnt, in_cnt);
        end

        // R5: backlog of 10 drains as one run of 10
        dst_run = 1'b0;
        src_wait(4);
        max_run = 0;
        back_to_back(10);
        in_cnt += 10;
        src_wait(6);
        dst_run = 1'b1;
        src_wait(60);
        chk(max_run == 10, "R5 run length", max_run, 10);
        chk(out_cnt == in_cnt, "R5 drained count", out_cnt, in_cnt);

        // R8 / R9: overflow at 15 waiting
        src_wait(10);
        dst_run = 1'b0;
        src_wait(4);
        back_to_back(15);
        in_cnt += 15;
        src_wait(3);
        chk(src_ovf == 1'b0, "R8 no ovf at 15 waiting (R9)", src_ovf, 0);
        burst(1, 1);
        src_wait(2);
        chk(src_ovf == 1'b1, "R8 ovf on 16th (R9)", src_ovf, 1);
        dst_run = 1'b1;
        src_wait(80);
        chk(out_cnt == in_cnt, "R8 15 reproduced, 16th refused", out_cnt, in_cnt);
        chk(src_ovf == 1'b1, "R8 ovf sticky", src_ovf, 1);

        // R1: reset clears and stays quiet
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        src_wait(4);
        chk(src_ovf == 1'b0, "R1 ovf cleared in reset", src_ovf, 0);
        chk(dst_evt == 1'b0, "R1 dst_evt low in reset", dst_evt, 0);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        src_wait(40);
        chk(out_cnt == in_cnt, "R1 quiet after reset", out_cnt, in_cnt);
        burst(1, 1);
        in_cnt++;
        src_wait(20);
        chk(out_cnt == in_cnt, "R1 first pulse after reset (R4)", out_cnt, in_cnt);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule